// File: doc/BRIEF.md
# Capture/Compare Universal Timer

A general-purpose application timer built around a 32-bit up counter. The counter advances on ticks from a 7-bit prescaler. The prescaler is fed either by every system clock cycle or by synchronized rising edges on a GPIO input. When the counter reaches a programmable limit, it either wraps to zero or parks there, depending on the auto-reload setting. A compare value toggles a GPIO output each time the counter arrives at it. A second GPIO input captures the running count on its rising edge.

Three sticky event flags record limit, compare and capture events. Each flag has its own enable, and the enabled flags are ORed into one interrupt line. Software programs the timer through a small word-addressed register port with a combinational read path. No data streams through the block, so every pin is a plain control or status signal and there is no valid/ready handshake.

Top module: `cc_timer`

## Requirements
- R1: While the timer is enabled and the counter is below the limit, every prescaler tick adds exactly one to the 32-bit count. With the clock as source and divide field P, the count is floor(M/(P+1)) M clock edges after the enabling write.
- R2: With auto-reload off, the counter stops at the limit value and stays there on later ticks.
- R3: With auto-reload on, a tick that finds the counter at the limit returns it to 0. The limit flag (status bit 0) is set only on the tick that brings the counter onto the limit, so it is set once per arrival.
- R4: The prescaler divides the source events by the control field bits 10:4 plus one, giving ratios from 1 to 128. It is cleared while the enable bit (control bit 0) is low.
- R5: When control bit 2 is 1, the source is the GPIO count input. Each rising edge, after a two-flop synchronizer, counts as one source event.
- R6: Each tick that moves the counter onto the compare value toggles `gpio_cmp_out` and sets the compare flag (status bit 1).
- R7: Suppose the capture input rises between clock edges a and a+1, counted from the enabling write, with the clock as source and a divide of 1. The capture register (address 4) then holds a+2, and the capture flag (status bit 2) is set.
- R8: Status bits are sticky and are cleared by writing 1 to them at address 5. A new event in the same cycle as a clear wins.
- R9: `irq` is high exactly when some status bit and its enable bit at address 6 are both 1.
- R10: After reset, the count, capture, status, compare output and `irq` are all 0.
- R11: The register map is: 0 control (bit 0 enable, bit 1 auto-reload, bit 2 source select, bits 10:4 divide), 1 limit, 2 compare, 3 count (a write loads the counter), 4 capture (read-only), 5 status, 6 interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| gpio_cnt_in | input | 1 | External count source |
| gpio_cap_in | input | 1 | External capture trigger |
| gpio_cmp_out | output | 1 | Output toggled on compare match |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a capture that lands on a known count. The capture edge has to cross the synchronizer and the edge detector while the counter keeps moving. The bench starts the counter from a write edge at a divide of 1. It then raises the capture pin after a swept number of edges and checks the captured value against the fixed three-register latency. Prescaler ratios and GPIO-sourced counting are swept over small ranges, with the expected counts worked out by integer division.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_LIM  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CAP  = 3'd4;
  localparam logic [ADDR_W-1:0] A_STS  = 3'd5;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd6;

  localparam int unsigned NUM_EV = 3;
  localparam int unsigned EV_LIM = 0;
  localparam int unsigned EV_CMP = 1;
  localparam int unsigned EV_CAP = 2;

  localparam int unsigned PSC_LSB = 4;

  typedef struct packed {
    logic [6:0] div;
    logic       src_gpio;
    logic       autoload;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/cct_edge_sync.sv
module cct_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~prev;

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/cct_prescaler.sv
module cct_prescaler #(
  parameter int unsigned PSC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             src_evt,
  input  logic [PSC_W-1:0] div,
  output logic             tick
);
  logic [PSC_W-1:0] pre;

  assign tick = en && src_evt && (pre >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre <= '0;
    else if (!en)     pre <= '0;
    else if (src_evt) pre <= tick ? '0 : pre + 1'b1;
  end

  p_tick_needs_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (src_evt && en));
  p_idle_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pre == '0));
endmodule

// File: rtl/cct_count_unit.sv
module cct_count_unit #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             autoload,
  input  logic [CNT_W-1:0] lim,
  input  logic [CNT_W-1:0] cmp,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             cap_evt,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap_val,
  output logic             out,
  output logic             hit_lim,
  output logic             hit_cmp
);
  logic [CNT_W-1:0] nxt;
  logic             at_lim;

  assign at_lim  = (cnt == lim);
  assign nxt     = at_lim ? (autoload ? '0 : cnt) : cnt + 1'b1;
  assign hit_lim = tick && !load && !at_lim && ((cnt + 1'b1) == lim);
  assign hit_cmp = tick && !load && (nxt != cnt) && (nxt == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (tick) cnt <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap_val <= '0;
    else if (cap_evt) cap_val <= cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       out <= 1'b0;
    else if (hit_cmp) out <= ~out;
  end

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !at_lim) |=> (cnt == $past(cnt) + 1'b1));
  p_hold_at_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!autoload && at_lim && !load) |=> (cnt == $past(cnt)));
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (autoload && tick && at_lim && !load) |=> (cnt == '0));
  p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_cmp |=> (out != $past(out)));
  p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_val == $past(cnt)));
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cct_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PSC_W  = 7,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              gpio_cnt_in,
  input  logic              gpio_cap_in,
  output logic              gpio_cmp_out,
  output logic              irq
);
  localparam int unsigned CTRL_W = PSC_LSB + PSC_W;

  ctrl_t             ctrl;
  logic [CNT_W-1:0]  lim_r, cmp_r, cnt, cap_val;
  logic [NUM_EV-1:0] sts, ien, ev_set, ev_clr;
  logic              cnt_rise, cap_rise, src_evt, tick, hit_lim, hit_cmp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      lim_r <= '1;
      cmp_r <= '1;
      ien   <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_CTRL: begin
          ctrl.run      <= reg_wdata[0];
          ctrl.autoload <= reg_wdata[1];
          ctrl.src_gpio <= reg_wdata[2];
          ctrl.div      <= reg_wdata[CTRL_W-1:PSC_LSB];
        end
        A_LIM:   lim_r <= reg_wdata[CNT_W-1:0];
        A_CMP:   cmp_r <= reg_wdata[CNT_W-1:0];
        A_IEN:   ien   <= reg_wdata[NUM_EV-1:0];
        default: ;
      endcase
    end
  end

  cct_edge_sync #(.STAGES(SYNC_N)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .din(gpio_cnt_in), .rise(cnt_rise));
  cct_edge_sync #(.STAGES(SYNC_N)) u_cap_sync (
    .clk(clk), .rst_n(rst_n), .din(gpio_cap_in), .rise(cap_rise));

  assign src_evt = ctrl.src_gpio ? cnt_rise : 1'b1;

  cct_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .en(ctrl.run), .src_evt(src_evt),
    .div(ctrl.div), .tick(tick));

  cct_count_unit #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .autoload(ctrl.autoload),
    .lim(lim_r), .cmp(cmp_r),
    .load(reg_we && (reg_addr == A_CNT)), .load_val(reg_wdata[CNT_W-1:0]),
    .cap_evt(cap_rise), .cnt(cnt), .cap_val(cap_val), .out(gpio_cmp_out),
    .hit_lim(hit_lim), .hit_cmp(hit_cmp));

  always_comb begin
    ev_set         = '0;
    ev_set[EV_LIM] = hit_lim;
    ev_set[EV_CMP] = hit_cmp;
    ev_set[EV_CAP] = cap_rise;
    ev_clr         = (reg_we && reg_addr == A_STS) ? reg_wdata[NUM_EV-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts <= '0;
    else        sts <= (sts & ~ev_clr) | ev_set;
  end

  assign irq = |(sts & ien);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[0]                = ctrl.run;
        reg_rdata[1]                = ctrl.autoload;
        reg_rdata[2]                = ctrl.src_gpio;
        reg_rdata[CTRL_W-1:PSC_LSB] = ctrl.div;
      end
      A_LIM:   reg_rdata[CNT_W-1:0]  = lim_r;
      A_CMP:   reg_rdata[CNT_W-1:0]  = cmp_r;
      A_CNT:   reg_rdata[CNT_W-1:0]  = cnt;
      A_CAP:   reg_rdata[CNT_W-1:0]  = cap_val;
      A_STS:   reg_rdata[NUM_EV-1:0] = sts;
      A_IEN:   reg_rdata[NUM_EV-1:0] = ien;
      default: reg_rdata = '0;
    endcase
  end

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[EV_LIM] && !ev_clr[EV_LIM]) |=> sts[EV_LIM]);
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_set[EV_CAP] |=> sts[EV_CAP]);
  p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);
endmodule

// File: tb/sim_cc_timer.sv
module sim_cc_timer;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_we = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        gpio_cnt_in = 0, gpio_cap_in = 0;
  logic        gpio_cmp_out, irq;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  cc_timer u0 (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gpio_cnt_in(gpio_cnt_in),
    .gpio_cap_in(gpio_cap_in), .gpio_cmp_out(gpio_cmp_out), .irq(irq));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  // write lands on the next posedge; returns just after it
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; #1;
    d = reg_rdata;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  function automatic logic [31:0] ctl(input bit en, input bit ar, input bit g, input int p);
    return {21'd0, p[6:0], 1'b0, g, ar, en};
  endfunction

  task automatic restart(input logic [31:0] lim, input logic [31:0] cmp);
    wr(3'd0, 32'd0);
    wr(3'd1, lim);
    wr(3'd2, cmp);
    wr(3'd3, 32'd0);
    wr(3'd5, 32'h7);
  endtask

  initial begin
    logic [31:0] v;
    bit          prev_out;
    #55 rst_n = 1;
    // R10 reset state
    rd(3'd3, v); chk("R10 count", v, 0);
    rd(3'd4, v); chk("R10 capture", v, 0);
    rd(3'd5, v); chk("R10 status", v, 0);
    chk("R10 cmp out", {31'd0, gpio_cmp_out}, 0);
    chk("R10 irq", {31'd0, irq}, 0);

    // R1 R4 prescaler sweep from the clock source
    for (int p = 0; p < 8; p++) begin
      for (int m = 3; m < 20; m += 7) begin
        restart(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        wr(3'd0, ctl(1, 0, 0, p));
        edges(m);
        rd(3'd3, v);
        chk("R1 R4 prescaled count", v, m / (p + 1));
      end
    end
    // R4 largest divide field
    restart(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    wr(3'd0, ctl(1, 0, 0, 127));
    edges(300);
    rd(3'd3, v); chk("R4 divide by 128", v, 300 / 128);

    // R2 no auto-reload: stops at limit
    for (int m = 2; m < 12; m += 3) begin
      restart(32'd5, 32'hFFFF_FFFF);
      wr(3'd0, ctl(1, 0, 0, 0));
      edges(m);
      rd(3'd3, v); chk("R2 stop at limit", v, (m < 5) ? m : 5);
    end
    rd(3'd5, v); chk("R3 limit flag after arrival", v & 1, 1);

    // R3 R6 auto-reload with compare
    for (int m = 1; m < 20; m += 2) begin
      restart(32'd5, 32'd3);
      prev_out = gpio_cmp_out;
      wr(3'd0, ctl(1, 1, 0, 0));
      edges(m);
      rd(3'd3, v); chk("R3 wrap count", v, m % 6);
      chk("R6 toggle parity", {31'd0, gpio_cmp_out ^ prev_out},
          (m >= 3) ? (((m - 3) / 6 + 1) % 2) : 0);
      rd(3'd5, v);
      chk("R3 limit flag", v & 1, (m >= 5) ? 1 : 0);
      chk("R6 compare flag", (v >> 1) & 1, (m >= 3) ? 1 : 0);
    end

    // R5 GPIO as count source
    for (int p = 0; p < 3; p++) begin
      for (int n = 1; n < 8; n += 3) begin
        restart(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        wr(3'd0, ctl(1, 0, 1, p));
        for (int k = 0; k < n; k++) begin
          @(negedge clk) gpio_cnt_in = 1;
          edges(2);
          @(negedge clk) gpio_cnt_in = 0;
          edges(2);
        end
        edges(4);
        rd(3'd3, v); chk("R5 gpio counted edges", v, n / (p + 1));
      end
    end

    // R7 capture latency sweep
    for (int a = 0; a < 6; a++) begin
      restart(32'hFFFF_FFFF, 32'hFFFF_FFFF);
      wr(3'd0, ctl(1, 0, 0, 0));
      edges(a);
      @(negedge clk) gpio_cap_in = 1;
      edges(6);
      @(negedge clk) gpio_cap_in = 0;
      rd(3'd4, v); chk("R7 captured value", v, a + 2);
      rd(3'd5, v); chk("R7 capture flag", (v >> 2) & 1, 1);
      edges(3);
    end

    // R8 R9 W1C and interrupt enable (capture flag is set now)
    wr(3'd0, 32'd0);
    wr(3'd6, 32'd0);
    #1 chk("R9 irq masked", {31'd0, irq}, 0);
    wr(3'd6, 32'h4);
    #1 chk("R9 irq enabled", {31'd0, irq}, 1);
    wr(3'd5, 32'h1);
    rd(3'd5, v); chk("R8 other bit kept", (v >> 2) & 1, 1);
    wr(3'd5, 32'h4);
    rd(3'd5, v); chk("R8 cleared", v, 0);
    #1 chk("R9 irq after clear", {31'd0, irq}, 0);
    // R11 readback of control and load
    wr(3'd0, ctl(0, 1, 1, 77));
    rd(3'd0, v); chk("R11 control readback", v, ctl(0, 1, 1, 77));
    wr(3'd3, 32'hDEAD_0001);
    rd(3'd3, v); chk("R11 count load", v, 32'hDEAD_0001);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule